// File: doc/BRIEF.md
# Reloadable Down-Counter Timer with Measurement Modes

This block is a down-counting timer, WIDTH bits wide, that advances on a count-source enable pulse. It has four operating modes. Timer mode counts ticks. Event-counter mode counts active edges of an external input. Pulse-width mode measures how long the input stays at its active level. Pulse-period mode measures the spacing between successive active edges. In every mode, a count past zero reloads the counter from a reload register, sets a sticky underflow flag and produces a one-cycle interrupt pulse.

Software starts and stops the timer through a start bit. A separate run-status bit follows the start bit only after three count-source ticks, which models the crossing of the command into the count-source domain. The measurement input passes through a synchronizer and an edge detector. A polarity bit picks the active edge and the active level.

In the two measurement modes, the counter value at the closing edge is captured into a read-out buffer. In these modes the counter address returns the buffer instead of the live counter. The edge flag and the underflow flag can only be cleared, by writing 0 to them; writing 1 leaves them as they are.

Top module: `rdtimer`

## Requirements
- R1: After reset, every register reads 0 at all four addresses: 0 counter, 1 control, 2 polarity, 3 mode. The timer does not count and irqPulse is low.
- R2: Writing control bit 0 (start) = 1 while stopped leaves status (control bit 1) at 0 for two count-source ticks. Status becomes 1 on the third tick. The first decrement happens on the tick after that.
- R3: Writing start = 0 while running keeps status at 1 and keeps the counter decrementing on the next three ticks. Status reads 0 after the third of these ticks, and the counter then stays frozen.
- R4: Timer mode (mode field bits 1:0 = 0) decrements once per tick while running. A tick at 0 reloads the counter from the reload value and sets the underflow flag (control bit 3). It also raises irqPulse for the one cycle after that tick.
- R5: A reload value of 0 produces an underflow, and so an irqPulse, on every tick while running.
- R6: Writing 0 to the edge flag (control bit 2) or to the underflow flag (control bit 3) clears it. Writing 1 to either flag leaves it unchanged.
- R7: Event mode (mode 1) decrements once per active input edge and ignores ticks. The active edge is rising when polarity (address 2, bit 0) = 0 and falling when polarity = 1. After k edges from reload value R, the counter reads R - k.
- R8: Pulse-width mode (mode 2) counts ticks while the input is at its active level. The active level is high for polarity 0 and low for polarity 1. At the closing edge the counter is captured, and the edge flag is set. With ticks on every cycle, a pulse of W cycles gives a buffer value of R - W + 1.
- R9: Pulse-period mode (mode 3) reloads the counter on every active edge. The first edge after start captures nothing and sets no flag. Each later edge captures the counter and sets the edge flag. With ticks on every cycle, a spacing of P cycles gives a buffer value of R - P + 1.
- R10: A write to address 0 loads both the reload value and the counter at once. Writes spaced three ticks apart all take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count-source enable, one tick per high cycle |
| evtIn | input | 1 | External event / measurement input (asynchronous) |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | WIDTH | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | WIDTH | Register read data (combinational) |
| irqPulse | output | 1 | One-cycle underflow interrupt pulse |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, a three-tick start/stop lag and a two-flop input synchronizer. With 16 bits, reload values of 1000 leave room for period and width measurements of several dozen cycles without underflow. Reload values of 0 to 11 in the random tick phase bring frequent underflows and reloads within reach. The three-tick lag is short enough for the bench to check the status bit and the counter on each tick of both the start and the stop transition.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER  = 2'd0,
    MODE_EVENT  = 2'd1,
    MODE_WIDTH  = 2'd2,
    MODE_PERIOD = 2'd3
  } modeT;

  typedef struct packed {
    logic dec;      // count one step down
    logic reload;   // restart from reload value (measurement edge)
    logic capture;  // copy counter into read-out buffer
  } strobeT;

  localparam logic [1:0] ADDR_CNT  = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_IOC  = 2'd2;
  localparam logic [1:0] ADDR_MODE = 2'd3;
endpackage

// File: rtl/rdt_ctrl.sv
module rdt_ctrl
  import rdt_pkg::*;
#(
  parameter int SYNC_TICKS  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       evtIn,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [3:0] wrData,
  input  logic       ufEvt,
  output strobeT     str,
  output logic       startReg,
  output logic       runStat,
  output logic       edgeFlag,
  output logic       ufFlag,
  output logic       polReg,
  output modeT       modeReg,
  output logic       irqPulse
);
  localparam int TW = (SYNC_TICKS > 1) ? $clog2(SYNC_TICKS) : 1;
  localparam logic [TW-1:0] LAST_TICK = TW'(SYNC_TICKS - 1);

  logic [TW-1:0] lagCnt;
  logic [SYNC_STAGES-1:0] syncVec;
  logic prevLvl, lvl, rise, fall, actEdge, endEdge, actLvl;
  logic firstDone;
  logic ctrlWr;

  assign ctrlWr = wrEn && (wrAddr == ADDR_CTRL);

  // input synchronizer and edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncVec <= '0;
      prevLvl <= 1'b0;
    end else begin
      syncVec <= {syncVec[SYNC_STAGES-2:0], evtIn};
      prevLvl <= lvl;
    end
  end

  always_comb begin
    lvl     = syncVec[SYNC_STAGES-1];
    rise    = lvl & ~prevLvl;
    fall    = ~lvl & prevLvl;
    actEdge = polReg ? fall : rise;
    endEdge = polReg ? rise : fall;
    actLvl  = lvl ^ polReg;
  end

  // software registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      startReg <= 1'b0;
      polReg   <= 1'b0;
      modeReg  <= MODE_TIMER;
    end else if (wrEn) begin
      if (wrAddr == ADDR_CTRL) startReg <= wrData[0];
      if (wrAddr == ADDR_IOC)  polReg   <= wrData[0];
      if (wrAddr == ADDR_MODE) modeReg  <= modeT'(wrData[1:0]);
    end
  end

  // start/stop lag measured in count-source ticks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runStat <= 1'b0;
      lagCnt  <= '0;
    end else if (startReg == runStat) begin
      lagCnt <= '0;
    end else if (tickEn) begin
      if (lagCnt == LAST_TICK) begin
        runStat <= startReg;
        lagCnt  <= '0;
      end else begin
        lagCnt <= lagCnt + 1'b1;
      end
    end
  end

  // first period edge only arms the measurement
  always_ff @(posedge clk) begin
    if (!rstN || !runStat)
      firstDone <= 1'b0;
    else if (modeReg == MODE_PERIOD && actEdge)
      firstDone <= 1'b1;
  end

  always_comb begin
    str = '0;
    if (runStat) begin
      unique case (modeReg)
        MODE_TIMER: str.dec = tickEn;
        MODE_EVENT: str.dec = actEdge;
        MODE_WIDTH: begin
          str.reload  = actEdge;
          str.capture = endEdge;
          str.dec     = tickEn & actLvl;
        end
        MODE_PERIOD: begin
          str.reload  = actEdge;
          str.capture = actEdge & firstDone;
          str.dec     = tickEn;
        end
        default: str = '0;
      endcase
    end
  end

  // sticky flags and interrupt
  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgeFlag <= 1'b0;
      ufFlag   <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      irqPulse <= ufEvt;
      if (str.capture)              edgeFlag <= 1'b1;
      else if (ctrlWr && !wrData[2]) edgeFlag <= 1'b0;
      if (ufEvt)                    ufFlag   <= 1'b1;
      else if (ctrlWr && !wrData[3]) ufFlag   <= 1'b0;
    end
  end

  AST_STATUS_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (runStat != $past(runStat)) |-> $past(tickEn)) else $error("status moved without tick"); // R2
  AST_STATUS_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rstN)
    (runStat != $past(runStat)) |-> (runStat == $past(startReg))) else $error("status against start"); // R3
  AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> ufFlag) else $error("irq without underflow flag"); // R4
  AST_FLAG_WRITE_ONE_NOOP: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(ufFlag) && !$past(ufEvt)) |-> !ufFlag) else $error("flag set by write"); // R6
endmodule

// File: rtl/rdt_datapath.sv
module rdt_datapath
  import rdt_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           str,
  input  logic             wrCnt,
  input  logic [WIDTH-1:0] wrVal,
  output logic [WIDTH-1:0] cntVal,
  output logic [WIDTH-1:0] bufVal,
  output logic             ufEvt
);
  logic [WIDTH-1:0] reloadReg;

  assign ufEvt = str.dec && !str.reload && !wrCnt && (cntVal == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadReg <= '0;
      cntVal    <= '0;
      bufVal    <= '0;
    end else begin
      if (wrCnt) begin
        reloadReg <= wrVal;
        cntVal    <= wrVal;
      end else if (str.reload) begin
        cntVal <= reloadReg;
      end else if (str.dec) begin
        cntVal <= ufEvt ? reloadReg : cntVal - 1'b1;
      end
      if (str.capture) bufVal <= cntVal;
    end
  end

  AST_FROZEN_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !($past(str.dec) || $past(str.reload) || $past(wrCnt)) |-> (cntVal == $past(cntVal)))
    else $error("counter moved with no strobe"); // R3
  AST_UF_RELOADS: assert property (@(posedge clk) disable iff (!rstN)
    $past(ufEvt) |-> (cntVal == reloadReg)) else $error("underflow did not reload"); // R4
endmodule

// File: rtl/rdtimer.sv
module rdtimer
  import rdt_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_TICKS  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             evtIn,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic [1:0]       rdAddr,
  output logic [WIDTH-1:0] rdData,
  output logic             irqPulse
);
  strobeT str;
  logic startReg, runStat, edgeFlag, ufFlag, polReg, ufEvt, wrCnt, measMode;
  modeT modeReg;
  logic [WIDTH-1:0] cntVal, bufVal;

  assign wrCnt    = wrEn && (wrAddr == ADDR_CNT);
  assign measMode = (modeReg == MODE_WIDTH) || (modeReg == MODE_PERIOD);

  rdt_ctrl #(.SYNC_TICKS(SYNC_TICKS), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .evtIn(evtIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData[3:0]), .ufEvt(ufEvt),
    .str(str), .startReg(startReg), .runStat(runStat), .edgeFlag(edgeFlag),
    .ufFlag(ufFlag), .polReg(polReg), .modeReg(modeReg), .irqPulse(irqPulse)
  );

  rdt_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk(clk), .rstN(rstN), .str(str), .wrCnt(wrCnt), .wrVal(wrData),
    .cntVal(cntVal), .bufVal(bufVal), .ufEvt(ufEvt)
  );

  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      ADDR_CNT:  rdData = measMode ? bufVal : cntVal;
      ADDR_CTRL: rdData[3:0] = {ufFlag, edgeFlag, runStat, startReg};
      ADDR_IOC:  rdData[0] = polReg;
      default:   rdData[1:0] = modeReg;
    endcase
  end
endmodule

// File: tb/rdtimer_tb_top.sv
module rdtimer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b1;
  logic evtIn = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [15:0] rdData;
  logic irqPulse;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdtimer dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .evtIn(evtIn), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .irqPulse(irqPulse)
  );

  function automatic logic [15:0] expMeas(input int r, input int len);
    return 16'(r - len + 1);
  endfunction

  function automatic logic [15:0] expEvents(input int r, input int k);
    return 16'(r - k);
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic periodEdge();
    evtIn = 1'b1; step(2); evtIn = 1'b0; step(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, c;
    int r, m, p, t;
    bit expIrq;
    void'($urandom(32'd2468));
    step(3);
    rstN = 1'b1;
    step(1);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1 reset read", v, 16'h0);
    end
    chk("R1 irq idle", 16'(irqPulse), 16'h0);

    // R10 counter writes three ticks apart
    regWrite(2'd0, 16'h1234); rd(2'd0, v); chk("R10 first write", v, 16'h1234);
    step(2);
    regWrite(2'd0, 16'h0055); rd(2'd0, v); chk("R10 spaced write", v, 16'h0055);
    step(3); rd(2'd0, v); chk("R1 no count when stopped", v, 16'h0055);

    // R2 start lag
    regWrite(2'd1, 16'h0001);
    rd(2'd1, v); chk("R2 status tick0", v & 16'h2, 16'h0);
    step(1); rd(2'd1, v); chk("R2 status tick1", v & 16'h2, 16'h0);
    step(1); rd(2'd1, v); chk("R2 status tick2", v & 16'h2, 16'h0);
    step(1); rd(2'd1, v); chk("R2 status tick3", v & 16'h2, 16'h2);
    rd(2'd0, v); chk("R2 no count before run", v, 16'h0055);
    step(1); rd(2'd0, v); chk("R2 first decrement", v, 16'h0054);

    // R3 stop lag
    rd(2'd0, c);
    regWrite(2'd1, 16'h0000);
    rd(2'd0, v); chk("R3 count at write", v, c - 16'd1);
    step(1); rd(2'd1, v); chk("R3 status hold1", v & 16'h2, 16'h2);
    step(1); rd(2'd1, v); chk("R3 status hold2", v & 16'h2, 16'h2);
    step(1); rd(2'd1, v); chk("R3 status off", v & 16'h2, 16'h0);
    rd(2'd0, v); chk("R3 final count", v, c - 16'd4);
    step(5); rd(2'd0, v); chk("R3 frozen", v, c - 16'd4);

    // R4 directed underflow
    regWrite(2'd0, 16'd4);
    regWrite(2'd1, 16'h0001);
    step(3); rd(2'd0, v); chk("R4 loaded", v, 16'd4);
    step(4); rd(2'd0, v); chk("R4 reached zero", v, 16'd0);
    chk("R4 no irq yet", 16'(irqPulse), 16'h0);
    step(1); rd(2'd0, v); chk("R4 reload", v, 16'd4);
    chk("R4 irq", 16'(irqPulse), 16'h1);
    rd(2'd1, v); chk("R4 uf flag", v & 16'h8, 16'h8);
    step(1); chk("R4 irq single", 16'(irqPulse), 16'h0);
    rd(2'd0, v); chk("R4 after reload", v, 16'd3);
    regWrite(2'd1, 16'h0008);
    step(5);

    // R6 flag write rules
    regWrite(2'd1, 16'h0008); rd(2'd1, v); chk("R6 write one keeps uf", v & 16'h8, 16'h8);
    regWrite(2'd1, 16'h0000); rd(2'd1, v); chk("R6 write zero clears uf", v & 16'h8, 16'h0);
    chk("R6 no irq stopped", 16'(irqPulse), 16'h0);

    // R5 reload of zero
    regWrite(2'd0, 16'd0);
    regWrite(2'd1, 16'h0001);
    step(3); chk("R5 idle before run", 16'(irqPulse), 16'h0);
    for (int i = 0; i < 5; i++) begin
      step(1); chk("R5 irq every tick", 16'(irqPulse), 16'h1);
    end
    regWrite(2'd1, 16'h0000); step(5);

    // R4 random tick pattern
    for (int rnd = 0; rnd < 3; rnd++) begin
      r = int'($urandom % 12);
      regWrite(2'd0, 16'(r));
      regWrite(2'd1, 16'h0001);
      step(3);
      m = r;
      rd(2'd0, v); chk("R4 random start", v, 16'(m));
      for (int i = 0; i < 200; i++) begin
        t = int'($urandom % 2);
        tickEn = t[0];
        step(1);
        expIrq = (t != 0) && (m == 0);
        if (t != 0) m = (m == 0) ? r : m - 1;
        rd(2'd0, v); chk("R4 random count", v, 16'(m));
        chk("R4 random irq", 16'(irqPulse), 16'(expIrq));
      end
      tickEn = 1'b1;
      regWrite(2'd1, 16'h0000); step(5);
    end

    // R7 event counting, rising then falling
    regWrite(2'd3, 16'd1); regWrite(2'd2, 16'd0); regWrite(2'd0, 16'd100);
    regWrite(2'd1, 16'h0001); step(3);
    step(4); rd(2'd0, v); chk("R7 ticks ignored", v, 16'd100);
    for (int i = 0; i < 7; i++) begin
      evtIn = 1'b1; step(3); evtIn = 1'b0; step(3);
    end
    step(4); rd(2'd0, v); chk("R7 rising edges", v, expEvents(100, 7));
    regWrite(2'd1, 16'h0000); step(5);
    regWrite(2'd2, 16'd1); regWrite(2'd0, 16'd50);
    regWrite(2'd1, 16'h0001); step(3);
    for (int i = 0; i < 5; i++) begin
      evtIn = 1'b1; step(3); evtIn = 1'b0; step(3);
    end
    step(4); rd(2'd0, v); chk("R7 falling edges", v, expEvents(50, 5));
    regWrite(2'd1, 16'h0000); step(5);

    // R8 pulse width, high then low
    regWrite(2'd3, 16'd2); regWrite(2'd2, 16'd0); regWrite(2'd0, 16'd500);
    regWrite(2'd1, 16'h0001); step(3);
    evtIn = 1'b1; step(9); evtIn = 1'b0; step(5);
    rd(2'd0, v); chk("R8 high width", v, expMeas(500, 9));
    rd(2'd1, v); chk("R8 edge flag", v & 16'h4, 16'h4);
    regWrite(2'd1, 16'h0000); step(5);
    regWrite(2'd2, 16'd1); evtIn = 1'b1; step(4);
    regWrite(2'd1, 16'h0001); step(3);
    rd(2'd1, v); chk("R6 edge flag cleared", v & 16'h4, 16'h0);
    evtIn = 1'b0; step(13); evtIn = 1'b1; step(5);
    rd(2'd0, v); chk("R8 low width", v, expMeas(500, 13));
    regWrite(2'd1, 16'h0000); step(5);

    // R9 pulse period
    evtIn = 1'b0;
    regWrite(2'd3, 16'd3); regWrite(2'd2, 16'd0); regWrite(2'd0, 16'd1000);
    step(4);
    regWrite(2'd1, 16'h0001); step(3);
    periodEdge();
    rd(2'd1, v); chk("R9 first edge no flag", v & 16'h4, 16'h0);
    rd(2'd0, v); chk("R9 first edge no capture", v, expMeas(500, 13));
    regWrite(2'd1, 16'h0001); step(20 - 6);
    periodEdge();
    rd(2'd1, v); chk("R9 second edge flag", v & 16'h4, 16'h4);
    rd(2'd0, v); chk("R9 period 20", v, expMeas(1000, 20));
    for (int i = 0; i < 4; i++) begin
      p = 8 + int'($urandom % 50);
      regWrite(2'd1, 16'h0001); step(p - 6);
      periodEdge();
      rd(2'd1, v); chk("R9 random flag", v & 16'h4, 16'h4);
      rd(2'd0, v); chk("R9 random period", v, expMeas(1000, p));
    end
    regWrite(2'd1, 16'h0000); step(5);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule